// File: doc/BRIEF.md
# Character Fetch Address Mapper

This block forms the display memory address for each character fetch of a text or graphics raster controller. A linear counter restarts at the first fetch of every scan line and steps on later fetches, either on every fetch or only on every second or fourth fetch. The counter value is added to the line's start address. The sum is then reshaped in a fixed order:

- scaling by one, two or four, with the bits that leave the top of the address rotated back in at the bottom;
- in word mode, a choice of the bit that fills address bit 0;
- optional replacement of address bits 13 and 14 by the low bits of the row-within-character counter.

The result is a 16-bit planar word address. Each such word holds four plane bytes: plane 0 in bits 7:0, plane 1 in bits 15:8, plane 2 in bits 23:16 and plane 3 in bits 31:24. The memory that returns this word is not part of the block.

The raster timing logic drives one fetch strobe per character fetch and flags the first fetch of each line. The mapped address appears one clock later, together with a valid strobe.

Top module: `crtc_fetch_addr_map`

## Requirements
- R1: While reset is held and in the cycle after it is released, `addr_valid` is 0 and `addr_out` is 0.
- R2: A fetch with `line_first` high uses counter value 0, so its linear address equals `line_start`.
- R3: A fetch with `line_first` low is the n-th fetch of the line (counting from n=0 at the `line_first` fetch). With both divide inputs low it uses counter value n. Cycles without a fetch never move the counter.
- R4: With `div4` high the counter value of fetch n is floor(n/4). With `div4` low and `div2` high it is floor(n/2). `div4` takes precedence over `div2`.
- R5: The linear address is (`line_start` + counter) mod 2^16. With `addr_mode` = 00 (byte) the scaled address equals the linear address L.
- R6: With `addr_mode` = 01 (word) the scaled address is {L[14:0], b}. b is L[15] when `wrap_sel` is 1 and L[13] when `wrap_sel` is 0.
- R7: With `addr_mode` = 10 or 11 (doubleword) the scaled address is {L[13:0], L[15:14]}.
- R8: After scaling, address bit 13 is replaced by `row_scan[0]` when `keep_a13` is 0. Address bit 14 is replaced by `row_scan[1]` when `keep_a14` is 0.
- R9: The mapped address is registered in the cycle after a fetch, with `addr_valid` high for exactly that cycle. In a cycle after no fetch, `addr_valid` is 0 and `addr_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_en | input | 1 | One character fetch in this cycle |
| line_first | input | 1 | This fetch is the first of the scan line |
| line_start | input | 16 | Start address of the current line |
| div2 | input | 1 | Advance the counter every second fetch |
| div4 | input | 1 | Advance the counter every fourth fetch (wins over div2) |
| addr_mode | input | 2 | 00 byte, 01 word, 1x doubleword scaling |
| wrap_sel | input | 1 | Word mode: bit 0 from L[15] (1) or L[13] (0) |
| keep_a13 | input | 1 | 0: address bit 13 takes row_scan[0] |
| keep_a14 | input | 1 | 0: address bit 14 takes row_scan[1] |
| row_scan | input | 2 | Low bits of the row-within-character counter |
| addr_out | output | 16 | Mapped planar word address |
| addr_valid | output | 1 | addr_out holds a new fetch address |

## Verification
Two kinds of event can land on the same fetch.

The first is a line restart while the clock divider is part-way through its period. Lines of eleven fetches end at a non-zero divider phase under divide-by-4. The next line's first fetch must still produce exactly `line_start`, and its later fetches must follow floor(n/r) from zero.

The second is the rotation of overflow bits and the row-scan substitution acting on one address. Line starts just below the 16-bit limit, and at the bit 13, 14 and 15 boundaries, are swept over all scaling modes, wrap choices and keep settings. Each result is compared with an address computed arithmetically in the bench.

// File: rtl/crtc_ma_pkg.sv
// Package: shared types for the fetch address mapper.
// Assumes a 2-bit mode field; code 2'b11 is decoded as doubleword.
package crtc_ma_pkg;

    typedef enum logic [1:0] {
        MA_BYTE  = 2'b00,
        MA_WORD  = 2'b01,
        MA_DWORD = 2'b10,
        MA_DWALT = 2'b11
    } ma_mode_e;

    localparam int unsigned MA_DIV_MAX = 4;

endpackage

// File: rtl/crtc_ma_counter.sv
// Module: linear fetch counter with a divide-by-1/2/4 prescaler.
// Produces cnt_use, the counter value that the current fetch uses: 0 on the
// first fetch of a line, otherwise the held value, stepped by one when the
// prescaler wraps. Assumes fetch_en is a single-cycle strobe per fetch.
module crtc_ma_counter #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_en,
    input  logic          line_first,
    input  logic          div2,
    input  logic          div4,
    output logic [AW-1:0] cnt_use
);
    import crtc_ma_pkg::*;

    localparam int unsigned PW = $clog2(MA_DIV_MAX);

    logic [AW-1:0] cnt_q;
    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_last;
    logic          step;

    // Pick the last prescaler phase before a step; div4 wins over div2.
    always_comb begin
        if (div4)      phase_last = PW'(MA_DIV_MAX - 1);
        else if (div2) phase_last = PW'(1);
        else           phase_last = '0;
    end

    // A later fetch steps the counter when the prescaler sits at its last phase.
    assign step = fetch_en && !line_first && (phase_q == phase_last);

    // Value used by this fetch: restart, step, or hold.
    always_comb begin
        if (fetch_en && line_first) cnt_use = '0;
        else if (step)              cnt_use = cnt_q + AW'(1);
        else                        cnt_use = cnt_q;
    end

    // Keep counter and prescaler phase; both restart on the line's first fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= '0;
        end else if (fetch_en) begin
            cnt_q <= cnt_use;
            if (line_first || step) phase_q <= '0;
            else                    phase_q <= phase_q + PW'(1);
        end
    end

    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && line_first) |=> (cnt_q == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_en) |=> $stable(cnt_q)); // R3

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !line_first) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + AW'(1)))); // R4

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!div4 && !div2 && fetch_en) |=> (phase_q == '0)); // R3

endmodule

// File: rtl/crtc_ma_scaler.sv
// Module: byte/word/doubleword scaling with overflow rotation and the
// word-mode bit-0 select. Purely combinational; assumes AW >= 16 so that
// WRAP_LO_BIT lies inside the address.
module crtc_ma_scaler #(
    parameter int unsigned AW          = 16,
    parameter int unsigned WRAP_LO_BIT = 13
) (
    input  logic [AW-1:0] lin,
    input  logic [1:0]    mode,
    input  logic          wrap_sel,
    output logic [AW-1:0] scaled
);
    import crtc_ma_pkg::*;

    ma_mode_e mode_e;
    assign mode_e = ma_mode_e'(mode);

    // Scale by 1, 2 or 4, rotating the bits pushed out at the top back in at bit 0.
    always_comb begin
        unique case (mode_e)
            MA_BYTE: scaled = lin;
            MA_WORD: begin
                scaled    = {lin[AW-2:0], lin[AW-1]};
                scaled[0] = wrap_sel ? lin[AW-1] : lin[WRAP_LO_BIT];
            end
            default: scaled = {lin[AW-3:0], lin[AW-1:AW-2]};
        endcase
    end

    always_comb begin
        if (mode_e == MA_BYTE) AST_BYTE_PASS: assert (scaled == lin); // R5
    end

endmodule

// File: rtl/crtc_ma_rowsub.sv
// Module: replaces two adjacent address bits by row-scan bits when the
// matching keep control is low. Combinational; assumes ROW_BIT+1 < AW.
module crtc_ma_rowsub #(
    parameter int unsigned AW      = 16,
    parameter int unsigned ROW_BIT = 13,
    parameter int unsigned NSUB    = 2
) (
    input  logic [AW-1:0]   addr_in,
    input  logic [NSUB-1:0] keep,
    input  logic [NSUB-1:0] row_scan,
    output logic [AW-1:0]   addr_sub
);
    // One mux per substituted bit, the rest pass straight through.
    always_comb begin
        addr_sub = addr_in;
        for (int i = 0; i < NSUB; i++) begin
            if (!keep[i]) addr_sub[ROW_BIT + i] = row_scan[i];
        end
    end

endmodule

// File: rtl/crtc_fetch_addr_map.sv
// Module: top of the fetch address mapper. Order of stages: counter,
// add line start, scale/rotate, word bit-0 select, row-scan substitution,
// output register. Assumes control inputs are steady within a line.
module crtc_fetch_addr_map #(
    parameter int unsigned AW          = 16,
    parameter int unsigned WRAP_LO_BIT = 13,
    parameter int unsigned ROW_BIT     = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_en,
    input  logic          line_first,
    input  logic [AW-1:0] line_start,
    input  logic          div2,
    input  logic          div4,
    input  logic [1:0]    addr_mode,
    input  logic          wrap_sel,
    input  logic          keep_a13,
    input  logic          keep_a14,
    input  logic [1:0]    row_scan,
    output logic [AW-1:0] addr_out,
    output logic          addr_valid
);
    localparam int unsigned NSUB = 2;

    logic [AW-1:0] cnt_use;
    logic [AW-1:0] lin;
    logic [AW-1:0] scaled;
    logic [AW-1:0] mapped;

    crtc_ma_counter #(.AW(AW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_en   (fetch_en),
        .line_first (line_first),
        .div2       (div2),
        .div4       (div4),
        .cnt_use    (cnt_use)
    );

    // Linear address: counter plus line start, kept to AW bits.
    assign lin = cnt_use + line_start;

    crtc_ma_scaler #(.AW(AW), .WRAP_LO_BIT(WRAP_LO_BIT)) u_scale (
        .lin      (lin),
        .mode     (addr_mode),
        .wrap_sel (wrap_sel),
        .scaled   (scaled)
    );

    crtc_ma_rowsub #(.AW(AW), .ROW_BIT(ROW_BIT), .NSUB(NSUB)) u_sub (
        .addr_in  (scaled),
        .keep     ({keep_a14, keep_a13}),
        .row_scan (row_scan),
        .addr_sub (mapped)
    );

    // Register the mapped address on a fetch and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out   <= '0;
            addr_valid <= 1'b0;
        end else begin
            addr_valid <= fetch_en;
            if (fetch_en) addr_out <= mapped;
        end
    end

    AST_VALID_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> addr_valid); // R9

    AST_HOLD_WITHOUT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> (!addr_valid && $stable(addr_out))); // R9

    AST_ROW_BIT13: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !keep_a13) |=> (addr_out[ROW_BIT] == $past(row_scan[0]))); // R8

    AST_ROW_BIT14: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !keep_a14) |=> (addr_out[ROW_BIT+1] == $past(row_scan[1]))); // R8

    AST_FIRST_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && line_first && addr_mode == 2'b00 && keep_a13 && keep_a14)
        |=> (addr_out == $past(line_start))); // R2

endmodule

// File: tb/tb_crtc_fetch_addr_map.sv
module tb_crtc_fetch_addr_map;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_en = 1'b0;
    logic        line_first = 1'b0;
    logic [15:0] line_start = '0;
    logic        div2 = 1'b0;
    logic        div4 = 1'b0;
    logic [1:0]  addr_mode = 2'b00;
    logic        wrap_sel = 1'b0;
    logic        keep_a13 = 1'b1;
    logic        keep_a14 = 1'b1;
    logic [1:0]  row_scan = 2'b00;
    logic [15:0] addr_out;
    logic        addr_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    crtc_fetch_addr_map dut (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .line_first(line_first),
        .line_start(line_start), .div2(div2), .div4(div4), .addr_mode(addr_mode),
        .wrap_sel(wrap_sel), .keep_a13(keep_a13), .keep_a14(keep_a14),
        .row_scan(row_scan), .addr_out(addr_out), .addr_valid(addr_valid)
    );

    // Reference address from the requirements (R5..R8).
    function automatic logic [15:0] ref_map(input logic [15:0] lin, input logic [1:0] md,
                                            input logic wr, input logic k13, input logic k14,
                                            input logic [1:0] rs);
        logic [15:0] a;
        if (md == 2'b00)      a = lin;
        else if (md == 2'b01) begin
            a    = {lin[14:0], 1'b0};
            a[0] = wr ? lin[15] : lin[13];
        end else              a = {lin[13:0], lin[15:14]};
        if (!k13) a[13] = rs[0];
        if (!k14) a[14] = rs[1];
        return a;
    endfunction

    task automatic check(input string req, input logic [15:0] got_a, input logic got_v,
                         input logic [15:0] exp_a, input logic exp_v);
        n_cmp++;
        if (got_a !== exp_a || got_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                     req, got_a, got_v, exp_a, exp_v);
        end
    endtask

    // One fetch; output checked just after the capturing edge.
    task automatic do_fetch(input logic first, input logic [1:0] rs, input logic [15:0] exp_a,
                            input string req);
        @(negedge clk);
        fetch_en = 1'b1; line_first = first; row_scan = rs;
        @(posedge clk); #1;
        check(req, addr_out, addr_valid, exp_a, 1'b1);
        @(negedge clk);
        fetch_en = 1'b0; line_first = 1'b0;
    endtask

    // One idle cycle: no valid, address held (R9), counter untouched (R3).
    task automatic do_idle(input logic [15:0] held);
        @(negedge clk);
        fetch_en = 1'b0;
        @(posedge clk); #1;
        check("R9 idle hold", addr_out, addr_valid, held, 1'b0);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] starts [5];
        starts[0] = 16'hFFFA; starts[1] = 16'h1FFE; starts[2] = 16'h3FFC;
        starts[3] = 16'h7FFD; starts[4] = 16'h0123;

        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", addr_out, addr_valid, 16'h0000, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", addr_out, addr_valid, 16'h0000, 1'b0);

        for (int md = 0; md < 3; md++)
        for (int wr = 0; wr < 2; wr++)
        for (int dv = 0; dv < 4; dv++)
        for (int kp = 0; kp < 4; kp++)
        for (int si = 0; si < 5; si++) begin
            int r;
            logic [15:0] last;
            @(negedge clk);
            addr_mode  = 2'(md);
            wrap_sel   = wr[0];
            div2       = dv[0];
            div4       = dv[1];
            keep_a13   = kp[0];
            keep_a14   = kp[1];
            line_start = starts[si];
            r = dv[1] ? 4 : (dv[0] ? 2 : 1);
            last = '0;
            // Eleven fetches per line: under divide-by-4 the line ends mid-period.
            for (int n = 0; n < 11; n++) begin
                logic [1:0]  rs;
                logic [15:0] lin;
                logic [15:0] exp_a;
                rs    = 2'(n ^ si);
                lin   = starts[si] + 16'(n / r);
                exp_a = ref_map(lin, 2'(md), wr[0], kp[0], kp[1], rs);
                if (n == 0)             do_fetch(1'b1, rs, exp_a, "R2 first fetch");
                else if (md == 0 && kp == 3 && dv == 0) do_fetch(1'b0, rs, exp_a, "R3 R5 byte step");
                else if (dv != 0 && md == 0 && kp == 3) do_fetch(1'b0, rs, exp_a, "R4 divided step");
                else if (md == 1 && kp == 3) do_fetch(1'b0, rs, exp_a, "R6 word wrap");
                else if (md == 2 && kp == 3) do_fetch(1'b0, rs, exp_a, "R7 dword rotate");
                else                    do_fetch(1'b0, rs, exp_a, "R8 row substitution");
                last = exp_a;
                if (n == 4 && si == 2) do_idle(last);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule